// File: doc/BRIEF.md
# Banked Translation-Bypass Attribute Unit

This block sits in front of the address translation path of a processor. It holds a system control register and two remap registers for each security world, Secure and Non-secure. For every memory request it picks the register copy that belongs to the request's own security state. If translation is off in that world, the block produces the result directly: a flat physical address, the security attribute, a memory-type code and an abort flag that is never set. If translation is on, the request goes out unchanged on a translation port so that an external page-table unit can handle it.

With translation off, the memory type is not fixed. The control register has a remap-mode bit. When remap mode is off, data accesses are strongly ordered and instruction accesses follow the instruction-cache enable bit. When remap mode is on, every access takes one default type held in the two remap registers, and the cache enable bits are ignored. The data-cache enable bit never makes a bypassed access cacheable. The outputs are combinational from the request and the registered state. A register write therefore takes effect for the next request.

Top module: `mmu_bypass_unit`

## Requirements
- R1: After synchronous reset (`rst_n` low at a clock edge), all control registers read as zero. Both `mmu_en_s` and `mmu_en_ns` are 0, so every request is bypassed.
- R2: Control state is banked. `req_ns`=0 selects the Secure copy and `req_ns`=1 selects the Non-secure copy. A write with `wr_ns`=0 or 1 changes only that world's copy. Register select codes: `wr_sel` 00 = control, 01 = primary remap, 10 = normal remap, 11 = no register.
- R3: When a valid request is bypassed (`byp_valid`=1), `byp_pa` equals `req_va`.
- R4: A bypassed request never raises `byp_abort`.
- R5: When a request is bypassed, `byp_ns` equals `req_ns`.
- R6: When remap mode (control bit 28) is 0, a bypassed data request (`req_instr`=0) has memory type 00 (strongly ordered), whatever the data-cache bit (bit 2) holds.
- R7: When remap mode is 0, a bypassed instruction request has type 11 (normal cacheable) if control bit 12 is 1, and type 00 if it is 0.
- R8: When remap mode is 1, every bypassed request takes the same type, and bits 2 and 12 have no effect. Memory-type codes are 00 strongly ordered, 01 device, 10 normal non-cacheable and 11 normal cacheable. The type is decided as follows:
  - If primary remap bit 1 is 0, the type is {0, primary bit 0}.
  - Otherwise the type is {1, normal-remap bit 0}.
- R9: The remap registers reset to zero. With remap mode on, this gives strongly ordered for every access.
- R10: A register write is visible to the request in the next cycle. A request in the same cycle as the write uses the old value.
- R11: When the selected world's control bit 0 is 1, the request appears unchanged on `xlat_valid`/`xlat_va`/`xlat_ns`/`xlat_instr`, and `byp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_ns | input | 1 | World of the write: 0 Secure, 1 Non-secure |
| wr_sel | input | 2 | Register select: 00 control, 01 primary remap, 10 normal remap |
| wr_data | input | 32 | Write data |
| req_valid | input | 1 | Request present |
| req_va | input | ADDR_W | Request virtual address |
| req_ns | input | 1 | Request security state: 1 Non-secure |
| req_instr | input | 1 | 1 for an instruction fetch, 0 for data |
| byp_valid | output | 1 | Bypass result valid |
| byp_pa | output | ADDR_W | Flat-mapped physical address |
| byp_ns | output | 1 | Target memory security attribute |
| byp_mem_type | output | 2 | Memory-type code |
| byp_abort | output | 1 | Abort flag (never set when bypassing) |
| xlat_valid | output | 1 | Request forwarded for translation |
| xlat_va | output | ADDR_W | Forwarded virtual address |
| xlat_ns | output | 1 | Forwarded security state |
| xlat_instr | output | 1 | Forwarded instruction/data flag |
| mmu_en_s | output | 1 | Secure world translation enable |
| mmu_en_ns | output | 1 | Non-secure world translation enable |

## Verification
The bench enables translation in one world and then sends a request from the other world. A design that does not bank its registers would forward that request instead of bypassing it. It sets the data-cache bit without remap mode, which would show up as a cacheable type if bit 2 leaked into bypass. It also sets both cache bits under remap mode, which exposes a design that lets bits 2 or 12 override the remap default. A request is placed in the same cycle as an enabling write to catch a design that forwards one cycle early. A reset after enabling catches enable bits that survive reset.

// File: rtl/mbu_pkg.sv
// Package: shared constants and types of the translation-bypass unit.
// Assumes 32-bit system registers; bit positions are fixed by the control map.
package mbu_pkg;
    localparam int REG_W   = 32;
    localparam int CTL_EN  = 0;   // translation enable
    localparam int CTL_DC  = 2;   // data cache enable
    localparam int CTL_IC  = 12;  // instruction cache enable
    localparam int CTL_RMP = 28;  // remap mode

    typedef enum logic [1:0] {
        MT_SO  = 2'b00,
        MT_DEV = 2'b01,
        MT_NC  = 2'b10,
        MT_WB  = 2'b11
    } mem_type_e;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'b00,
        SEL_PRIM = 2'b01,
        SEL_NORM = 2'b10,
        SEL_NONE = 2'b11
    } reg_sel_e;
endpackage

// File: rtl/mbu_bank.sv
// Module: one world's register bank (control, primary remap, normal remap).
// Assumes wr_en is already qualified by world; all registers reset to zero.
module mbu_bank
    import mbu_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [1:0]   wr_sel,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] ctrl_q,
    output logic [W-1:0] prim_q,
    output logic [W-1:0] norm_q
);
    // Capture writes to the selected register; clear everything on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            prim_q <= '0;
            norm_q <= '0;
        end else if (wr_en) begin
            case (wr_sel)
                SEL_CTRL: ctrl_q <= wr_data;
                SEL_PRIM: prim_q <= wr_data;
                SEL_NORM: norm_q <= wr_data;
                default:  ;
            endcase
        end
    end

    // R10: a control write is visible at the cycle after it
    a_r10_write_next: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en) && $past(wr_sel) == SEL_CTRL) |-> ctrl_q == $past(wr_data));
endmodule

// File: rtl/mbu_attr.sv
// Module: combinational memory-type decode for a bypassed request.
// Assumes the register inputs already belong to the request's world.
module mbu_attr
    import mbu_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic [W-1:0] ctrl,
    input  logic [W-1:0] prim,
    input  logic [W-1:0] norm,
    input  logic         instr,
    output logic [1:0]   mem_type
);
    // Pick the remap default or the compatible cache-bit rule.
    always_comb begin
        if (ctrl[CTL_RMP]) begin
            mem_type = prim[1] ? {1'b1, norm[0]} : {1'b0, prim[0]};
        end else if (instr && ctrl[CTL_IC]) begin
            mem_type = MT_WB;
        end else begin
            mem_type = MT_SO;
        end
    end
endmodule

// File: rtl/mbu_route.sv
// Module: steers a request to the bypass result or the translation port.
// Assumes en is the request world's translation enable.
module mbu_route #(
    parameter int AW = 32
) (
    input  logic          req_valid,
    input  logic [AW-1:0] req_va,
    input  logic          req_ns,
    input  logic          req_instr,
    input  logic          en,
    output logic          byp_valid,
    output logic [AW-1:0] byp_pa,
    output logic          byp_ns,
    output logic          byp_abort,
    output logic          xlat_valid,
    output logic [AW-1:0] xlat_va,
    output logic          xlat_ns,
    output logic          xlat_instr
);
    // Route by enable; the bypass path maps flat and never aborts.
    always_comb begin
        byp_valid  = req_valid && !en;
        byp_pa     = req_va;
        byp_ns     = req_ns;
        byp_abort  = 1'b0;
        xlat_valid = req_valid && en;
        xlat_va    = req_va;
        xlat_ns    = req_ns;
        xlat_instr = req_instr;
    end
endmodule

// File: rtl/mmu_bypass_unit.sv
// Module: top of the banked translation-bypass attribute unit.
// Assumes one request per cycle; outputs are combinational from registered state.
module mmu_bypass_unit
    import mbu_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int WORLDS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_ns,
    input  logic [1:0]        wr_sel,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_va,
    input  logic              req_ns,
    input  logic              req_instr,
    output logic              byp_valid,
    output logic [ADDR_W-1:0] byp_pa,
    output logic              byp_ns,
    output logic [1:0]        byp_mem_type,
    output logic              byp_abort,
    output logic              xlat_valid,
    output logic [ADDR_W-1:0] xlat_va,
    output logic              xlat_ns,
    output logic              xlat_instr,
    output logic              mmu_en_s,
    output logic              mmu_en_ns
);
    logic [REG_W-1:0] ctrl_w [WORLDS];
    logic [REG_W-1:0] prim_w [WORLDS];
    logic [REG_W-1:0] norm_w [WORLDS];
    logic [REG_W-1:0] sel_ctrl, sel_prim, sel_norm;

    // One register bank per security world.
    for (genvar w = 0; w < WORLDS; w++) begin : g_bank
        mbu_bank #(.W(REG_W)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_en && (wr_ns == 1'(w))),
            .wr_sel  (wr_sel),
            .wr_data (wr_data),
            .ctrl_q  (ctrl_w[w]),
            .prim_q  (prim_w[w]),
            .norm_q  (norm_w[w])
        );
    end

    // Select the bank that matches the request's security state.
    always_comb begin
        sel_ctrl = req_ns ? ctrl_w[1] : ctrl_w[0];
        sel_prim = req_ns ? prim_w[1] : prim_w[0];
        sel_norm = req_ns ? norm_w[1] : norm_w[0];
    end

    assign mmu_en_s  = ctrl_w[0][CTL_EN];
    assign mmu_en_ns = ctrl_w[1][CTL_EN];

    mbu_attr #(.W(REG_W)) u_attr (
        .ctrl     (sel_ctrl),
        .prim     (sel_prim),
        .norm     (sel_norm),
        .instr    (req_instr),
        .mem_type (byp_mem_type)
    );

    mbu_route #(.AW(ADDR_W)) u_route (
        .req_valid  (req_valid),
        .req_va     (req_va),
        .req_ns     (req_ns),
        .req_instr  (req_instr),
        .en         (sel_ctrl[CTL_EN]),
        .byp_valid  (byp_valid),
        .byp_pa     (byp_pa),
        .byp_ns     (byp_ns),
        .byp_abort  (byp_abort),
        .xlat_valid (xlat_valid),
        .xlat_va    (xlat_va),
        .xlat_ns    (xlat_ns),
        .xlat_instr (xlat_instr)
    );

    // R1: both enables are clear right after reset
    a_r1_reset_off: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!mmu_en_s && !mmu_en_ns));
    // R3: flat mapping on bypass
    a_r3_flat_pa: assert property (@(posedge clk) disable iff (!rst_n)
        byp_valid |-> byp_pa == req_va);
    // R5: security attribute follows the request
    a_r5_ns_follow: assert property (@(posedge clk) disable iff (!rst_n)
        byp_valid |-> byp_ns == req_ns);
    // R6: data is strongly ordered outside remap mode
    a_r6_data_so: assert property (@(posedge clk) disable iff (!rst_n)
        (byp_valid && !req_instr && !sel_ctrl[CTL_RMP]) |-> byp_mem_type == MT_SO);
    // R11: a request goes to exactly one destination
    a_r11_one_path: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> $countones({byp_valid, xlat_valid}) == 1);
endmodule

// File: tb/tb_mmu_bypass_unit.sv
module tb_mmu_bypass_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, wr_ns = 1'b0;
    logic [1:0]  wr_sel = 2'b00;
    logic [31:0] wr_data = '0;
    logic        req_valid = 1'b0, req_ns = 1'b0, req_instr = 1'b0;
    logic [31:0] req_va = '0;
    logic        byp_valid, byp_ns, byp_abort, xlat_valid, xlat_ns, xlat_instr;
    logic        mmu_en_s, mmu_en_ns;
    logic [31:0] byp_pa, xlat_va;
    logic [1:0]  byp_mem_type;
    int checks = 0, errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    mmu_bypass_unit dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ns(wr_ns), .wr_sel(wr_sel),
        .wr_data(wr_data), .req_valid(req_valid), .req_va(req_va), .req_ns(req_ns),
        .req_instr(req_instr), .byp_valid(byp_valid), .byp_pa(byp_pa), .byp_ns(byp_ns),
        .byp_mem_type(byp_mem_type), .byp_abort(byp_abort), .xlat_valid(xlat_valid),
        .xlat_va(xlat_va), .xlat_ns(xlat_ns), .xlat_instr(xlat_instr),
        .mmu_en_s(mmu_en_s), .mmu_en_ns(mmu_en_ns)
    );

    typedef struct packed {
        logic        ns;
        logic        instr;
        logic [31:0] ctrl;
        logic [31:0] prim;
        logic [31:0] norm;
        logic [31:0] va;
        logic [1:0]  exp_type;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b0, 32'h0000_0000, 32'h0, 32'h0, 32'h0000_1000, 2'b00}, // R6
        '{1'b0, 1'b0, 32'h0000_0004, 32'h0, 32'h0, 32'h8000_0004, 2'b00}, // R6 bit2 ignored
        '{1'b0, 1'b1, 32'h0000_1000, 32'h0, 32'h0, 32'h1234_5678, 2'b11}, // R7
        '{1'b0, 1'b1, 32'h0000_0000, 32'h0, 32'h0, 32'hFFFF_FFFC, 2'b00}, // R7
        '{1'b1, 1'b1, 32'h0000_1000, 32'h0, 32'h0, 32'h0000_0040, 2'b11}, // R7
        '{1'b1, 1'b0, 32'h0000_1004, 32'h0, 32'h0, 32'hA5A5_0000, 2'b00}, // R6
        '{1'b0, 1'b0, 32'h1000_0000, 32'h1, 32'h0, 32'h0BAD_F00D, 2'b01}, // R8
        '{1'b0, 1'b1, 32'h1000_1000, 32'h2, 32'h0, 32'h0000_2000, 2'b10}, // R8 bit12 ignored
        '{1'b1, 1'b0, 32'h1000_0004, 32'h2, 32'h1, 32'h7000_0000, 2'b11}, // R8 bit2 ignored
        '{1'b1, 1'b1, 32'h1000_1004, 32'h0, 32'h1, 32'h0000_0008, 2'b00}  // R8
    };

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic wr(input logic ns, input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_ns = ns; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic req(input logic ns, input logic instr, input logic [31:0] va);
        req_valid = 1'b1; req_ns = ns; req_instr = instr; req_va = va;
        #1;
    endtask

    // Compound check of a bypassed result: valid, flat PA, NS, type, no abort.
    task automatic chk_byp(input string tag, input logic [31:0] va, input logic ns,
                           input logic [1:0] ty);
        chk(byp_valid && !xlat_valid && byp_pa == va && byp_ns == ns &&
            byp_mem_type == ty && !byp_abort, tag, "bypass result",
            {byp_valid, xlat_valid, byp_abort, byp_ns, byp_mem_type, byp_pa},
            {1'b1, 1'b0, 1'b0, ns, ty, va});
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!mmu_en_s && !mmu_en_ns, "R1", "enables after reset", {mmu_en_s, mmu_en_ns}, 2'b00);
        req(1'b0, 1'b1, 32'hCAFE_0000);
        chk_byp("R1", 32'hCAFE_0000, 1'b0, 2'b00);

        // R9 remap registers at reset give strongly ordered
        wr(1'b0, 2'b00, 32'h1000_1004);
        req(1'b0, 1'b1, 32'h0000_0100);
        chk_byp("R9", 32'h0000_0100, 1'b0, 2'b00);
        req(1'b0, 1'b0, 32'h0000_0200);
        chk_byp("R9", 32'h0000_0200, 1'b0, 2'b00);

        // Vector table: program the world, then issue one request
        for (int i = 0; i < NV; i++) begin
            wr(VEC[i].ns, 2'b00, VEC[i].ctrl);
            wr(VEC[i].ns, 2'b01, VEC[i].prim);
            wr(VEC[i].ns, 2'b10, VEC[i].norm);
            req(VEC[i].ns, VEC[i].instr, VEC[i].va);
            chk_byp($sformatf("R3/R4/R5/R6/R7/R8 vec%0d", i), VEC[i].va, VEC[i].ns, VEC[i].exp_type);
            req_valid = 1'b0;
        end

        // R10 / R11: a request in the write cycle uses the old (disabled) value
        @(negedge clk);
        wr(1'b0, 2'b00, 32'h0);
        @(negedge clk);
        wr_en = 1'b1; wr_ns = 1'b0; wr_sel = 2'b00; wr_data = 32'h0000_0001;
        req(1'b0, 1'b0, 32'h4444_0000);
        chk_byp("R10", 32'h4444_0000, 1'b0, 2'b00);
        @(negedge clk);
        wr_en = 1'b0;
        #1;
        chk(xlat_valid && !byp_valid && xlat_va == 32'h4444_0000 && !xlat_ns && !xlat_instr,
            "R11", "forwarded request", {xlat_valid, byp_valid, xlat_ns, xlat_instr, xlat_va},
            {1'b1, 1'b0, 1'b0, 1'b0, 32'h4444_0000});
        req(1'b0, 1'b1, 32'h5555_0000);
        chk(xlat_valid && xlat_instr && xlat_va == 32'h5555_0000, "R11", "forward instr",
            {xlat_valid, xlat_instr, xlat_va}, {1'b1, 1'b1, 32'h5555_0000});
        chk(mmu_en_s && !mmu_en_ns, "R2", "only Secure enabled", {mmu_en_s, mmu_en_ns}, 2'b10);
        // R2: Non-secure request still bypasses
        req(1'b1, 1'b0, 32'h6666_0000);
        chk_byp("R2", 32'h6666_0000, 1'b1, 2'b00);

        // R2: select code 11 writes nothing
        wr(1'b1, 2'b11, 32'hFFFF_FFFF);
        req(1'b1, 1'b1, 32'h7777_0000);
        chk(!mmu_en_ns && byp_valid && byp_mem_type == 2'b00, "R2", "select 11 ignored",
            {mmu_en_ns, byp_valid, byp_mem_type}, {1'b0, 1'b1, 2'b00});

        // R1: reset clears an enabled world
        wr(1'b1, 2'b00, 32'h0000_0001);
        chk(mmu_en_ns, "R2", "Non-secure enabled", mmu_en_ns, 1'b1);
        req_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(!mmu_en_s && !mmu_en_ns, "R1", "enables after second reset",
            {mmu_en_s, mmu_en_ns}, 2'b00);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule